// File: doc/BRIEF.md
# Four-Symbol Pattern Recognizer

This block watches a stream of symbols that arrive one per clock from a four-letter alphabet (q, r, w, z). It raises a single match bit each time a target pattern finishes. A symbol takes part only in a cycle where its valid strobe is high. The match bit is a Moore output: it is a direct function of the state register. It therefore appears in the cycle after the completing symbol is accepted.

A mode input selects one of two patterns. In fixed mode the pattern is the sequence r, r, z. Runs overlap, so a longer run of r symbols followed by z still matches. In run mode the pattern is one or more r symbols followed by z. The mode is taken into account only when a z is accepted, so a run that has already started is judged by the mode in force at its closing z.

Top module: `sym_pattern_detect`

## Requirements
- R1: Symbols are coded q=2'b00, r=2'b01, w=2'b10, z=2'b11. Exactly one symbol is accepted at each rising clock edge where `sym_valid` is high.
- R2: In fixed mode (`mode_run`=0), a match is reported for an accepted z exactly when the two symbols accepted just before it were both r. The stream q r w z r r z r z r r r z w yields the match stream 0 0 0 0 0 0 1 0 0 0 0 0 1 0.
- R3: In fixed mode, a run of any length of two or more r symbols followed by z matches. A single r followed by z does not match.
- R4: In run mode (`mode_run`=1), an accepted z matches when the symbol accepted just before it was r. On the R2 example stream, this mode reports matches at positions 7, 9 and 13.
- R5: `match` goes high in the cycle after the edge that accepts the completing z. It stays high for exactly one cycle.
- R6: A cycle with `sym_valid` low accepts no symbol and leaves the progress through a run unchanged. For example, r, gap, r, gap, z still matches in fixed mode. `match` is low in the cycle after such an edge.
- R7: An accepted q or w clears all progress. An accepted z that completes no match also clears all progress.
- R8: Synchronous reset drives `match` low and clears all progress. A run begun before reset does not count after it.
- R9: The mode is sampled only at the edge that accepts z. Changing `mode_run` in the middle of a run does not disturb the progress already made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sym | input | SYM_W (2) | Symbol code |
| sym_valid | input | 1 | High when `sym` carries a symbol to accept |
| mode_run | input | 1 | 0 selects the fixed r r z pattern; 1 selects the r-run-then-z pattern |
| match | output | 1 | One-cycle pulse when a pattern completes |

## Verification
The bench targets three corner cases.

- A third or later r in a run must keep the detector armed. A design that restarts its count on every r would miss r r r z.
- Gaps in the valid strobe must be invisible. A design that advances or clears on an idle cycle would either miss a gapped run or report a phantom match.
- The match pulse must drop even when no symbol follows it. A design that holds its hit state would stretch the pulse across idle cycles.

Beyond these, the bench toggles the mode in the middle of a run to catch a design that latches the mode at the first r. It also asserts reset between an r r prefix and a z, to catch progress that survives reset. Every five-symbol sequence is swept in both modes against an arithmetic count of trailing r symbols.

// File: rtl/sym_match_pkg.sv
package sym_match_pkg;

   // progress states; order matters only for the one-hot index mapping
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ONE_R = 2'd1,
      ST_TWO_R = 2'd2,
      ST_HIT   = 2'd3
   } st_e;

   localparam int NUM_ST = 4;

   // decoded view of the incoming symbol
   typedef struct packed {
      logic is_r;
      logic is_z;
      logic is_clr;
   } cls_t;

endpackage

// File: rtl/sym_classify.sv
module sym_classify
   import sym_match_pkg::*;
#(
   parameter int SYM_W  = 2,
   parameter int CODE_Q = 0,
   parameter int CODE_R = 1,
   parameter int CODE_W = 2,
   parameter int CODE_Z = 3
) (
   input  logic [SYM_W-1:0] sym,
   output cls_t             cls
);

   localparam logic [SYM_W-1:0] K_Q = SYM_W'(CODE_Q);
   localparam logic [SYM_W-1:0] K_R = SYM_W'(CODE_R);
   localparam logic [SYM_W-1:0] K_W = SYM_W'(CODE_W);
   localparam logic [SYM_W-1:0] K_Z = SYM_W'(CODE_Z);

   always_comb begin
      cls.is_r   = (sym == K_R);
      cls.is_z   = (sym == K_Z);
      cls.is_clr = (sym == K_Q) || (sym == K_W);
   end

endmodule

// File: rtl/sym_next_state.sv
module sym_next_state
   import sym_match_pkg::*;
(
   input  st_e  cur,
   input  cls_t cls,
   input  logic valid,
   input  logic mode_run,
   output st_e  nxt
);

   st_e base;

   // after a hit the run is spent; continue from idle
   always_comb begin
      base = (cur == ST_HIT) ? ST_IDLE : cur;
   end

   always_comb begin
      nxt = base;
      if (valid) begin
         case (base)
            ST_IDLE: begin
               if (cls.is_r)        nxt = ST_ONE_R;
               else                 nxt = ST_IDLE;
            end
            ST_ONE_R: begin
               if (cls.is_r)        nxt = ST_TWO_R;
               else if (cls.is_z)   nxt = mode_run ? ST_HIT : ST_IDLE;
               else                 nxt = ST_IDLE;
            end
            ST_TWO_R: begin
               if (cls.is_r)        nxt = ST_TWO_R;
               else if (cls.is_z)   nxt = ST_HIT;
               else if (cls.is_clr) nxt = ST_IDLE;
               else                 nxt = ST_IDLE;
            end
            default:                nxt = ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/sym_state_reg.sv
module sym_state_reg
   import sym_match_pkg::*;
#(
   parameter bit ONE_HOT = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  st_e  nxt,
   output st_e  cur,
   output logic hit
);

   generate
      if (ONE_HOT) begin : g_onehot
         logic [NUM_ST-1:0] oh_q;

         always_ff @(posedge clk) begin
            if (rst) begin
               oh_q           <= '0;
               oh_q[ST_IDLE]  <= 1'b1;
            end else begin
               oh_q           <= '0;
               oh_q[nxt]      <= 1'b1;
            end
         end

         always_comb begin
            cur = ST_IDLE;
            for (int i = 0; i < NUM_ST; i++) begin
               if (oh_q[i]) cur = st_e'(2'(i));
            end
         end

         assign hit = oh_q[ST_HIT];
      end else begin : g_binary
         st_e st_q;

         always_ff @(posedge clk) begin
            if (rst) st_q <= ST_IDLE;
            else     st_q <= nxt;
         end

         assign cur = st_q;
         assign hit = (st_q == ST_HIT);
      end
   endgenerate

endmodule

// File: rtl/sym_pattern_detect.sv
module sym_pattern_detect
   import sym_match_pkg::*;
#(
   parameter int SYM_W   = 2,
   parameter int CODE_Q  = 0,
   parameter int CODE_R  = 1,
   parameter int CODE_W  = 2,
   parameter int CODE_Z  = 3,
   parameter bit ONE_HOT = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SYM_W-1:0] sym,
   input  logic             sym_valid,
   input  logic             mode_run,
   output logic             match
);

   localparam int CODE_LIM = 1 << SYM_W;

   // elaboration-time parameter checks
   generate
      if (SYM_W < 2) begin : g_bad_width
         $error("SYM_W must hold four codes");
      end
      if (CODE_Q >= CODE_LIM || CODE_R >= CODE_LIM ||
          CODE_W >= CODE_LIM || CODE_Z >= CODE_LIM ||
          CODE_Q < 0 || CODE_R < 0 || CODE_W < 0 || CODE_Z < 0) begin : g_bad_range
         $error("symbol code outside SYM_W range");
      end
      if (CODE_Q == CODE_R || CODE_Q == CODE_W || CODE_Q == CODE_Z ||
          CODE_R == CODE_W || CODE_R == CODE_Z || CODE_W == CODE_Z) begin : g_bad_dup
         $error("symbol codes must be distinct");
      end
   endgenerate

   cls_t cls;
   st_e  cur;
   st_e  nxt;
   logic hit;

   sym_classify #(
      .SYM_W (SYM_W),
      .CODE_Q(CODE_Q),
      .CODE_R(CODE_R),
      .CODE_W(CODE_W),
      .CODE_Z(CODE_Z)
   ) u_cls (
      .sym(sym),
      .cls(cls)
   );

   sym_next_state u_nxt (
      .cur     (cur),
      .cls     (cls),
      .valid   (sym_valid),
      .mode_run(mode_run),
      .nxt     (nxt)
   );

   sym_state_reg #(
      .ONE_HOT(ONE_HOT)
   ) u_reg (
      .clk(clk),
      .rst(rst),
      .nxt(nxt),
      .cur(cur),
      .hit(hit)
   );

   assign match = hit;

endmodule

// File: rtl/sym_pattern_detect_chk.sv
module sym_pattern_detect_chk #(
   parameter int SYM_W  = 2,
   parameter int CODE_Q = 0,
   parameter int CODE_R = 1,
   parameter int CODE_W = 2,
   parameter int CODE_Z = 3
) (
   input logic             clk,
   input logic             rst,
   input logic [SYM_W-1:0] sym,
   input logic             sym_valid,
   input logic             mode_run,
   input logic             match
);

   logic acc_r, acc_z, acc_clr;
   assign acc_r   = sym_valid && (sym == SYM_W'(CODE_R));
   assign acc_z   = sym_valid && (sym == SYM_W'(CODE_Z));
   assign acc_clr = sym_valid && ((sym == SYM_W'(CODE_Q)) || (sym == SYM_W'(CODE_W)));

   p_reset_clear_r8: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !match);

   p_one_cycle_r5: assert property (@(posedge clk) disable iff (rst)
      match |=> !match);

   p_gap_no_hit_r6: assert property (@(posedge clk) disable iff (rst)
      !sym_valid |=> !match);

   p_clear_sym_r7: assert property (@(posedge clk) disable iff (rst)
      acc_clr |=> !match);

   p_r_no_hit_r3: assert property (@(posedge clk) disable iff (rst)
      acc_r |=> !match);

   p_run_hit_r4: assert property (@(posedge clk) disable iff (rst)
      (acc_z && mode_run && $past(acc_r) && !$past(rst)) |=> match);

   p_fixed_hit_r2: assert property (@(posedge clk) disable iff (rst)
      (acc_z && !mode_run && $past(acc_r) && $past(acc_r, 2) &&
       !$past(rst) && !$past(rst, 2)) |=> match);

endmodule

bind sym_pattern_detect sym_pattern_detect_chk #(
   .SYM_W (SYM_W),
   .CODE_Q(CODE_Q),
   .CODE_R(CODE_R),
   .CODE_W(CODE_W),
   .CODE_Z(CODE_Z)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .sym      (sym),
   .sym_valid(sym_valid),
   .mode_run (mode_run),
   .match    (match)
);

// File: tb/sim_sym_pattern_detect.sv
`timescale 1ns/1ps
module sim_sym_pattern_detect;

   localparam int Q = 0, R = 1, W = 2, Z = 3;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] sym = 2'd0;
   logic       sym_valid = 1'b0;
   logic       mode_run = 1'b0;
   logic       match;

   int checks = 0;
   int failures = 0;
   int run_len = 0;   // reference: trailing accepted r count
   bit done = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   sym_pattern_detect u0 (
      .clk(clk), .rst(rst), .sym(sym),
      .sym_valid(sym_valid), .mode_run(mode_run), .match(match)
   );

   task automatic check(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: match=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   // called at a negedge; returns at the next negedge after checking
   task automatic step(input string tag, input int s, input bit v, input bit m);
      logic exp;
      sym = 2'(s); sym_valid = v; mode_run = m;
      exp = 1'b0;
      if (v) begin
         if (s == R) begin
            run_len++;
         end else if (s == Z) begin
            exp = (run_len >= (m ? 1 : 2));
            run_len = 0;
         end else begin
            run_len = 0;
         end
      end
      @(posedge clk);
      @(negedge clk);
      check(tag, match, exp);
   endtask

   task automatic do_reset();
      rst = 1'b1; sym_valid = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check("R8", match, 1'b0);
      rst = 1'b0;
      run_len = 0;
   endtask

   initial begin
      int ex_stream [14] = '{Q, R, W, Z, R, R, Z, R, Z, R, R, R, Z, W};
      bit ex_fixed  [14] = '{0,0,0,0,0,0,1,0,0,0,0,0,1,0};
      bit ex_run    [14] = '{0,0,0,0,0,0,1,0,1,0,0,0,1,0};
      bit [31:0] lfsr = 32'hACE1_2345;

      @(negedge clk);
      @(negedge clk);
      check("R8", match, 1'b0);
      rst = 1'b0;

      // R2: example stream, fixed mode, literal expected values
      do_reset();
      for (int i = 0; i < 14; i++) begin
         sym = 2'(ex_stream[i]); sym_valid = 1'b1; mode_run = 1'b0;
         @(posedge clk); @(negedge clk);
         check("R2", match, ex_fixed[i]);
      end
      // R4: example stream, run mode
      do_reset();
      for (int i = 0; i < 14; i++) begin
         sym = 2'(ex_stream[i]); sym_valid = 1'b1; mode_run = 1'b1;
         @(posedge clk); @(negedge clk);
         check("R4", match, ex_run[i]);
      end

      // R3: long run, single r
      do_reset();
      step("R3", R, 1, 0); step("R3", R, 1, 0); step("R3", R, 1, 0);
      step("R3", R, 1, 0); step("R3", Z, 1, 0);
      step("R3", R, 1, 0); step("R3", Z, 1, 0);

      // R5: pulse drops with no following symbol
      do_reset();
      step("R5", R, 1, 1); step("R5", Z, 1, 1);
      step("R5", Z, 0, 1); step("R5", Z, 0, 1);

      // R6: gaps do not disturb progress
      do_reset();
      step("R6", R, 1, 0); step("R6", Q, 0, 0); step("R6", R, 1, 0);
      step("R6", W, 0, 0); step("R6", Z, 0, 0); step("R6", Z, 1, 0);

      // R7: clearing symbols and an unmatched z
      do_reset();
      step("R7", R, 1, 0); step("R7", W, 1, 0); step("R7", R, 1, 0);
      step("R7", Z, 1, 0);
      step("R7", R, 1, 0); step("R7", Q, 1, 0); step("R7", Z, 1, 1);

      // R9: mode sampled at z
      do_reset();
      step("R9", R, 1, 1); step("R9", R, 1, 1); step("R9", Z, 1, 0);
      step("R9", R, 1, 0); step("R9", Z, 1, 1);
      step("R9", R, 1, 1); step("R9", Z, 1, 0);

      // R8: reset between prefix and z
      do_reset();
      step("R8", R, 1, 0); step("R8", R, 1, 0);
      do_reset();
      step("R8", Z, 1, 0);

      // R1/R2/R4: every five-symbol sequence in both modes
      for (int m = 0; m < 2; m++) begin
         for (int seq = 0; seq < 1024; seq++) begin
            do_reset();
            for (int k = 0; k < 5; k++) begin
               step(m ? "R1_R4" : "R1_R2", (seq >> (2 * k)) & 3, 1'b1, 1'(m));
            end
         end
      end

      // R6/R9: pseudo-random gaps and mode changes
      do_reset();
      for (int n = 0; n < 4000; n++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         step("R6_R9", (lfsr[1:0] == 2'd0) ? Z : ((lfsr[2] ? R : int'(lfsr[1:0]))),
              lfsr[4] | lfsr[5], lfsr[7] & lfsr[9]);
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: done=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule